// File: doc/BRIEF.md
# YUV 4:2:2 Overlay Alpha Blender

This block mixes a graphics overlay into a main video stream one YUV 4:2:2 pixel pair at a time. Each accepted transfer carries the four main-image bytes of a pair and the four overlay bytes for the same position. The alpha is not a separate channel. The lowest bit of the overlay's first chroma byte chooses one of two programmable alpha weights for the first pixel. The lowest bit of the overlay's second chroma byte makes the same choice for the second luma sample. Those two chroma bytes are then mixed with that bit forced to zero. The mixed pair leaves one byte per cycle, chroma-blue first, on a valid/ready output.

The input side is a valid/ready pair interface. Alongside it runs an overlay-enable bit that is captured with each pair. The two alpha weights sit in a small register bank written through a strobe, a select bit and a data byte. Each pair captures the bank at the moment it is accepted, so a write never changes a pair that is already in the pipeline. Inside, there is a capture stage and a blend stage. These feed a byte serializer run by a five-state machine: SER_IDLE, SER_U0, SER_Y0, SER_V0 and SER_Y1. The machine goes SER_IDLE to SER_U0 when it loads a blended pair. From SER_U0 it moves to SER_Y0, then SER_V0, then SER_Y1, each step on an output handshake. From SER_Y1, a handshake takes it back to SER_U0 if another blended pair is waiting, or to SER_IDLE if none is. Without a handshake every state holds.

Top module: `ovl_blend422`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and both alpha weights are zero, so an enabled pair sent first comes out equal to the main bytes.
- R2: A pair accepted at clock edge n into an empty block has out_valid low after edges n and n+1, and presents its U0 byte from edge n+2.
- R3: Bytes of a pair leave in the order U0, Y0, V0, Y1, tagged by out_pos = 0, 1, 2, 3. On the 32-bit pair buses U0 is bits 31:24, Y0 is bits 23:16, V0 is bits 15:8 and Y1 is bits 7:0.
- R4: A pair accepted with ovl_en low is emitted byte-for-byte equal to its main bytes, whatever the overlay and alpha values.
- R5: With ovl_en high, each output byte equals floor((a*ov + (256-a)*mn + 128) / 256), limited to 255. Here a is the chosen 8-bit alpha, ov is the overlay byte and mn is the main byte.
- R6: Overlay bit 24 (the U0 LSB) chooses the alpha for U0, Y0 and V0. The value 0 picks the weight written with alpha_wr_sel = 0, and the value 1 picks the weight written with alpha_wr_sel = 1.
- R7: Overlay bit 8 (the V0 LSB) chooses the alpha for Y1, with the same 0/1 meaning as in R6.
- R8: The overlay U0 and V0 bytes are mixed with their bit 0 taken as zero. The overlay Y0 and Y1 bytes are mixed with all eight bits.
- R9: While out_valid is high and out_ready is low, out_valid, out_byte and out_pos keep their values.
- R10: An alpha write at edge n applies to pairs accepted after edge n. Pairs accepted at or before edge n keep the weights they captured.
- R11: ovl_en is sampled per pair at acceptance. Changing it later does not affect a pair already accepted.
- R12: in_ready is high whenever the capture stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair will be taken at this edge |
| main_pair | input | 4*PIX_W | Main U0,Y0,V0,Y1 bytes, U0 in the top byte |
| ovl_pair | input | 4*PIX_W | Overlay U0,Y0,V0,Y1 bytes, same layout |
| ovl_en | input | 1 | Overlay enable, captured with the pair |
| alpha_wr_en | input | 1 | Alpha weight write strobe |
| alpha_wr_sel | input | 1 | Selects which weight is written (0 or 1) |
| alpha_wr_data | input | ALPHA_W | New weight value |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte at this edge |
| out_byte | output | PIX_W | Blended byte |
| out_pos | output | 2 | Byte position within the pair, 0 = U0 through 3 = Y1 |

## Verification
The bench sweeps alpha across all 256 values with the extreme bytes 0x00 and 0xFF on each side. This exposes an off-by-one in the weight complement: with alpha zero the output would no longer equal the main byte, and rounding errors would show at the top of the range. It also sets every combination of the two chroma select bits with the two weights pinned to 0 and 255. A design that used the wrong bit, or one bit for all four bytes, would then emit main bytes where overlay bytes belong. The same sweep with chroma LSB set catches a design that skipped the LSB masking, because its chroma output would be one higher. Random output stalls, and an alpha write or enable change landing while a pair sits stalled in the serializer, expose designs that advance or corrupt a held byte or that read the weights live instead of per pair.

// File: rtl/ovb_pkg.sv
package ovb_pkg;

    // Bytes per 4:2:2 pixel pair, numbered in output order.
    localparam int LANES    = 4;
    localparam int POS_W    = 2;
    localparam int LANE_U0  = 0;
    localparam int LANE_Y0  = 1;
    localparam int LANE_V0  = 2;
    localparam int LANE_Y1  = 3;

    typedef enum logic [2:0] {
        SER_IDLE = 3'd0,
        SER_U0   = 3'd1,
        SER_Y0   = 3'd2,
        SER_V0   = 3'd3,
        SER_Y1   = 3'd4
    } ser_state_e;

endpackage

// File: rtl/ovb_alpha_bank.sv
module ovb_alpha_bank #(
    parameter int ALPHA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [ALPHA_W-1:0] wr_data,
    output logic [ALPHA_W-1:0] alpha_zero,
    output logic [ALPHA_W-1:0] alpha_one
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alpha_zero <= '0;
            alpha_one  <= '0;
        end else if (wr_en) begin
            if (wr_sel) alpha_one  <= wr_data;
            else        alpha_zero <= wr_data;
        end
    end

endmodule

// File: rtl/ovb_lane.sv
module ovb_lane #(
    parameter int PIX_W    = 8,
    parameter int ALPHA_W  = 8,
    parameter bit MASK_LSB = 1'b0
) (
    input  logic [PIX_W-1:0]   main_px,
    input  logic [PIX_W-1:0]   ovl_px,
    input  logic [ALPHA_W-1:0] alpha,
    input  logic               en,
    output logic [PIX_W-1:0]   mixed
);

    localparam int SUM_W = PIX_W + ALPHA_W + 2;
    localparam logic [SUM_W-1:0] FULL_WT = SUM_W'(1) << ALPHA_W;
    localparam logic [SUM_W-1:0] HALF_WT = SUM_W'(1) << (ALPHA_W - 1);
    localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

    logic [PIX_W-1:0] ovl_eff;
    logic [SUM_W-1:0] wt_ovl;
    logic [SUM_W-1:0] wt_main;
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] scaled;

    generate
        if (MASK_LSB) begin : g_chroma
            assign ovl_eff = {ovl_px[PIX_W-1:1], 1'b0};
        end else begin : g_luma
            assign ovl_eff = ovl_px;
        end
    endgenerate

    always_comb begin
        wt_ovl  = SUM_W'(alpha);
        wt_main = FULL_WT - wt_ovl;
        acc     = wt_ovl * SUM_W'(ovl_eff) + wt_main * SUM_W'(main_px) + HALF_WT;
        scaled  = acc >> ALPHA_W;
        if (!en) begin
            mixed = main_px;
        end else if (scaled > PIX_MAX) begin
            mixed = '1;
        end else begin
            mixed = scaled[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/ovb_serializer.sv
module ovb_serializer
    import ovb_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_valid,
    input  logic [LANES*PIX_W-1:0] load_data,
    output logic                   load_take,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [PIX_W-1:0]       out_byte,
    output logic [POS_W-1:0]       out_pos
);

    ser_state_e             state_q;
    ser_state_e             state_d;
    logic [LANES*PIX_W-1:0] hold_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load_take) begin
            hold_q <= load_data;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE: if (load_valid) state_d = SER_U0;
            SER_U0:   if (out_ready)  state_d = SER_Y0;
            SER_Y0:   if (out_ready)  state_d = SER_V0;
            SER_V0:   if (out_ready)  state_d = SER_Y1;
            SER_Y1:   if (out_ready)  state_d = load_valid ? SER_U0 : SER_IDLE;
            default:                  state_d = SER_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b1;
        out_pos   = POS_W'(LANE_U0);
        load_take = 1'b0;
        unique case (state_q)
            SER_IDLE: begin
                out_valid = 1'b0;
                load_take = load_valid;
            end
            SER_U0: out_pos = POS_W'(LANE_U0);
            SER_Y0: out_pos = POS_W'(LANE_Y0);
            SER_V0: out_pos = POS_W'(LANE_V0);
            SER_Y1: begin
                out_pos   = POS_W'(LANE_Y1);
                load_take = load_valid && out_ready;
            end
            default: out_valid = 1'b0;
        endcase
        out_byte = hold_q[(LANES-1-int'(out_pos))*PIX_W +: PIX_W];
    end

endmodule

// File: rtl/ovl_blend422.sv
module ovl_blend422
    import ovb_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int ALPHA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [4*PIX_W-1:0]     main_pair,
    input  logic [4*PIX_W-1:0]     ovl_pair,
    input  logic                   ovl_en,
    input  logic                   alpha_wr_en,
    input  logic                   alpha_wr_sel,
    input  logic [ALPHA_W-1:0]     alpha_wr_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [PIX_W-1:0]       out_byte,
    output logic [1:0]             out_pos
);

    localparam int BUS_W    = LANES * PIX_W;
    localparam int SEL_U_BIT = (LANES - 1 - LANE_U0) * PIX_W;
    localparam int SEL_V_BIT = (LANES - 1 - LANE_V0) * PIX_W;

    logic [ALPHA_W-1:0] alpha_zero;
    logic [ALPHA_W-1:0] alpha_one;

    // Capture stage.
    logic               cap_v;
    logic [BUS_W-1:0]   cap_main;
    logic [BUS_W-1:0]   cap_ovl;
    logic [ALPHA_W-1:0] cap_a0;
    logic [ALPHA_W-1:0] cap_a1;
    logic               cap_en;

    // Blend stage.
    logic               blend_v;
    logic [BUS_W-1:0]   blend_data;
    logic [BUS_W-1:0]   lane_out;
    logic               blend_adv;
    logic               ser_take;

    ovb_alpha_bank #(.ALPHA_W(ALPHA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (alpha_wr_en),
        .wr_sel     (alpha_wr_sel),
        .wr_data    (alpha_wr_data),
        .alpha_zero (alpha_zero),
        .alpha_one  (alpha_one)
    );

    assign blend_adv = cap_v && (!blend_v || ser_take);
    assign in_ready  = !cap_v || blend_adv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_v <= 1'b0;
        end else if (in_ready) begin
            cap_v <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_main <= '0;
            cap_ovl  <= '0;
            cap_a0   <= '0;
            cap_a1   <= '0;
            cap_en   <= 1'b0;
        end else if (in_valid && in_ready) begin
            cap_main <= main_pair;
            cap_ovl  <= ovl_pair;
            cap_a0   <= alpha_zero;
            cap_a1   <= alpha_one;
            cap_en   <= ovl_en;
        end
    end

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int  LO      = (LANES - 1 - i) * PIX_W;
            localparam bit  IS_CHR  = (i == LANE_U0) || (i == LANE_V0);
            localparam bit  USE_V   = (i == LANE_Y1);
            logic               pick;
            logic [ALPHA_W-1:0] a_sel;

            assign pick  = USE_V ? cap_ovl[SEL_V_BIT] : cap_ovl[SEL_U_BIT];
            assign a_sel = pick ? cap_a1 : cap_a0;

            ovb_lane #(
                .PIX_W   (PIX_W),
                .ALPHA_W (ALPHA_W),
                .MASK_LSB(IS_CHR)
            ) u_lane (
                .main_px (cap_main[LO +: PIX_W]),
                .ovl_px  (cap_ovl[LO +: PIX_W]),
                .alpha   (a_sel),
                .en      (cap_en),
                .mixed   (lane_out[LO +: PIX_W])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blend_v <= 1'b0;
        end else if (blend_adv) begin
            blend_v <= 1'b1;
        end else if (ser_take) begin
            blend_v <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blend_data <= '0;
        end else if (blend_adv) begin
            blend_data <= lane_out;
        end
    end

    ovb_serializer #(.PIX_W(PIX_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (blend_v),
        .load_data  (blend_data),
        .load_take  (ser_take),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_pos    (out_pos)
    );

endmodule

// File: rtl/ovb_checker.sv
module ovb_checker #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_byte,
    input logic [1:0]       out_pos,
    input logic             cap_v,
    input logic             blend_v
);

    // R9: a stalled byte is held.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_pos));

    // R3: positions step by one inside a pair.
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_pos != 2'd3 |=> out_valid && out_pos == $past(out_pos) + 2'd1);

    // R3: after the last byte, either idle or a new pair starting at U0.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_pos == 2'd3 |=> !out_valid || out_pos == 2'd0);

    // R3: output always opens a burst at U0.
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_pos == 2'd0);

    // R2: fixed fill latency from an empty block.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !cap_v && !blend_v && !out_valid
        |=> !out_valid ##1 !out_valid ##1 out_valid);

    // R12: empty capture stage always accepts.
    p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_v |-> in_ready);

endmodule

bind ovl_blend422 ovb_checker #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_pos   (out_pos),
    .cap_v     (cap_v),
    .blend_v   (blend_v)
);

// File: tb/sim_ovl_blend422.sv
module sim_ovl_blend422;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int AW = 8;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   main_pair = '0;
    logic [31:0]   ovl_pair = '0;
    logic          ovl_en = 1'b0;
    logic          alpha_wr_en = 1'b0;
    logic          alpha_wr_sel = 1'b0;
    logic [7:0]    alpha_wr_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [7:0]    out_byte;
    logic [1:0]    out_pos;

    ovl_blend422 #(.PIX_W(PW), .ALPHA_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .main_pair(main_pair), .ovl_pair(ovl_pair), .ovl_en(ovl_en),
        .alpha_wr_en(alpha_wr_en), .alpha_wr_sel(alpha_wr_sel), .alpha_wr_data(alpha_wr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_pos(out_pos)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;
    bit          done = 1'b0;
    string       cur_req = "R5";
    logic [9:0]  exp_q[$];
    logic [7:0]  m_a0 = 8'd0;
    logic [7:0]  m_a1 = 8'd0;
    bit          stall_mode = 1'b0;
    bit          hard_stall = 1'b0;
    logic [15:0] rdy_lfsr = 16'hACE1;
    logic [15:0] dat_lfsr = 16'h1D35;
    bit          prev_stall = 1'b0;
    logic [7:0]  prev_byte = '0;
    logic [1:0]  prev_pos = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] mn, input logic [7:0] ov,
                                         input logic [7:0] a, input bit en);
        int s;
        if (!en) return mn;
        s = (int'(a) * int'(ov) + (256 - int'(a)) * int'(mn) + 128) / 256;
        if (s > 255) s = 255;
        return s[7:0];
    endfunction

    task automatic rand32(output logic [31:0] w);
        for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 16; b++)
                dat_lfsr = {dat_lfsr[14:0], dat_lfsr[15] ^ dat_lfsr[13] ^ dat_lfsr[12] ^ dat_lfsr[10]};
            w = {w[15:0], dat_lfsr};
        end
    endtask

    task automatic push_pair(input logic [31:0] mn, input logic [31:0] ov, input bit en);
        logic [7:0] au;
        logic [7:0] av;
        au = ov[24] ? m_a1 : m_a0;
        av = ov[8]  ? m_a1 : m_a0;
        exp_q.push_back({2'd0, model(mn[31:24], {ov[31:25], 1'b0}, au, en)});
        exp_q.push_back({2'd1, model(mn[23:16], ov[23:16], au, en)});
        exp_q.push_back({2'd2, model(mn[15:8], {ov[15:9], 1'b0}, au, en)});
        exp_q.push_back({2'd3, model(mn[7:0], ov[7:0], av, en)});
    endtask

    task automatic send(input logic [31:0] mn, input logic [31:0] ov, input bit en);
        @(negedge clk); #1;
        in_valid = 1'b1; main_pair = mn; ovl_pair = ov; ovl_en = en;
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        push_pair(mn, ov, en);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic write_alpha(input bit sel, input logic [7:0] val);
        @(negedge clk); #1;
        alpha_wr_en = 1'b1; alpha_wr_sel = sel; alpha_wr_data = val;
        @(posedge clk); #1;
        alpha_wr_en = 1'b0;
        if (sel) m_a1 = val; else m_a0 = val;
    endtask

    // Output monitor: drives out_ready, compares every handshake.
    always begin
        @(negedge clk);
        out_ready = hard_stall ? 1'b0 : (stall_mode ? rdy_lfsr[0] : 1'b1);
        rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                // R9: held byte unchanged
                check(out_valid && out_byte == prev_byte && out_pos == prev_pos,
                      "R9", int'(out_byte), int'(prev_byte));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected byte", int'(out_byte), -1);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check(out_pos == e[9:8], "R3", int'(out_pos), int'(e[9:8]));
                    check(out_byte == e[7:0], cur_req, int'(out_byte), int'(e[7:0]));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            prev_pos   = out_pos;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog R2 act=%0d exp=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic drain();
        for (int k = 0; k < 4000 && exp_q.size() != 0; k++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        logic [31:0] mn;
        logic [31:0] ov;
        logic [7:0]  alist [6];
        alist = '{8'd0, 8'd1, 8'd64, 8'd128, 8'd200, 8'd255};

        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R2 latency, R1 zero alphas pass main bytes through even when enabled
        cur_req = "R1";
        send(32'hA1B2C3D4, 32'h5F6E7D8C, 1'b1);
        check(out_valid == 1'b0, "R2 edge n", int'(out_valid), 0);
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R2 edge n+1", int'(out_valid), 0);
        @(posedge clk); #1;
        check(out_valid == 1'b1, "R2 edge n+2", int'(out_valid), 1);
        check(out_byte == 8'hA1, "R2 first byte", int'(out_byte), 8'hA1);
        drain();

        // R4: disabled overlay
        cur_req = "R4";
        write_alpha(1'b0, 8'd200);
        write_alpha(1'b1, 8'd255);
        for (int i = 0; i < 24; i++) begin
            rand32(mn); rand32(ov);
            send(mn, ov, 1'b0);
        end
        drain();

        // R5: alpha pair sweep with random data and extremes
        cur_req = "R5";
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                write_alpha(1'b0, alist[i]);
                write_alpha(1'b1, alist[j]);
                send(32'h00000000, 32'hFFFFFFFF, 1'b1);
                send(32'hFFFFFFFF, 32'h00000000, 1'b1);
                send(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1);
                for (int k = 0; k < 8; k++) begin
                    rand32(mn); rand32(ov);
                    send(mn, ov, 1'b1);
                end
            end
        end
        drain();

        // R5: every alpha value, extreme operands
        for (int a = 0; a < 256; a++) begin
            write_alpha(1'b0, 8'(a));
            send(32'h00FF00FF, 32'hFE00FE00, 1'b1);
            send(32'hFF00FF00, 32'h00FE00FE, 1'b1);
        end
        drain();

        // R6/R7/R8: select bits with weights pinned to 0 and 255
        write_alpha(1'b0, 8'd0);
        write_alpha(1'b1, 8'd255);
        for (int s = 0; s < 4; s++) begin
            cur_req = (s[0]) ? "R7" : "R6";
            mn = 32'h10203040;
            ov = {8'hE0 | 8'(s[1]), 8'hD1, 8'hC0 | 8'(s[0]), 8'hB3};
            send(mn, ov, 1'b1);
            cur_req = "R8";
            ov = {8'hFF, 8'h7F, 8'hFF, 8'h81};
            ov[24] = s[1]; ov[8] = s[0];
            send(32'h00000000, ov, 1'b1);
            drain();
        end

        // R9/R11: random stalls, enable toggled per pair
        cur_req = "R11";
        stall_mode = 1'b1;
        write_alpha(1'b0, 8'd90);
        write_alpha(1'b1, 8'd170);
        for (int i = 0; i < 250; i++) begin
            rand32(mn); rand32(ov);
            send(mn, ov, bit'(i % 3 != 0));
        end
        drain();
        stall_mode = 1'b0;

        // R10/R11: change weights and enable while a pair is held in the serializer
        cur_req = "R10";
        hard_stall = 1'b1;
        send(32'h20406080, 32'hE1C1A181, 1'b1);
        repeat (6) @(posedge clk);
        write_alpha(1'b0, 8'd10);
        write_alpha(1'b1, 8'd40);
        send(32'h20406080, 32'hE1C1A181, 1'b1);
        send(32'h11223344, 32'h99AABBCC, 1'b0);
        repeat (3) @(posedge clk);
        hard_stall = 1'b0;
        drain();

        check(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);
        #2;
        check(out_valid == 1'b0, "R12 idle valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R12 idle ready", int'(in_ready), 1);
        finish_run();
    end

endmodule